// File: doc/BRIEF.md
# Synchronous Burst SRAM Front-End

This block is the clocked control front-end of a small synchronous burst SRAM. Two active-low address strobes compete for the address register. One comes from a processor and is qualified by an active-low chip enable. The other comes from a controller and is not qualified. On an accepted strobe the full address is registered, and its two low bits seed a 2-bit burst counter. While no strobe is accepted, an active-low advance input steps that counter in linear order and leaves the upper address bits alone.

Reads are pipelined: the registered burst address is looked up at the next rising edge. The word therefore appears on the data output one clock after the address was taken. Write data is registered at the edge of the write access and committed to the array one edge later. A bypass keeps a read of that address correct in the meantime. The bidirectional bus appears as separate data-in, data-out and drive-enable signals. An active-high sleep input freezes all activity without losing memory contents. After sleep ends, the block waits one idle cycle before it accepts accesses again.

Top module: `burst_sram_frontend`

## Requirements
- R1: At a rising edge where a strobe is accepted, the whole address is registered as the burst address, with bits 1:0 loaded into the burst counter. The word at that address appears on `dq_out` after the following edge.
- R2: When both strobes are low at the same edge and `ce1_n` is low, the processor strobe wins. That access is a read, so `we_n` low does not write the array.
- R3: The processor strobe has no effect while `ce1_n` is high. The burst address keeps its value when no other access is present.
- R4: The controller strobe is accepted regardless of `ce1_n`.
- R5: At an edge with no accepted strobe and `adv_n` low, the 2-bit counter increments 0,1,2,3,0. Address bits above bit 1 are unchanged.
- R6: A write happens on an edge with an accepted controller strobe, or an accepted advance, together with `we_n` low. It stores `dq_in` sampled at that edge at the new burst address. Processor-strobe edges never write.
- R7: Read latency is one clock. Back-to-back strobes at consecutive edges yield the corresponding words at consecutive edges.
- R8: `dq_oe` is registered: after an edge, it is 1 exactly when `oe_n` was low and `sleep` was low at that edge. When `oe_n` was high it is 0, meaning the bus is tri-stated.
- R9: While `sleep` is high at an edge, strobes, advances and writes are ignored. `dq_out` holds its value, `dq_oe` goes to 0, and memory contents are kept.
- R10: At the first edge after `sleep` falls, accesses are still ignored. Accesses are accepted from the edge after that.
- R11: A synchronous active-high `rst` clears the burst address to 0, clears `dq_out` to 0 and drives `dq_oe` to 0.
- R12: A read of an address written at the previous edge returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| proc_stb_n | input | 1 | Processor address strobe, active low |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| ce1_n | input | 1 | Chip enable qualifying the processor strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| sleep | input | 1 | Low-activity request, active high; hold low when unused |
| addr | input | ADDR_W | Word address |
| dq_in | input | DATA_W | Bus data toward the array |
| dq_out | output | DATA_W | Registered read data |
| dq_oe | output | 1 | Bus drive enable; 0 means tri-state |

## Verification
The array is filled through controller strobes with chip enable high. It is then read back with processor strobes, once with an idle cycle between reads and once back to back. This separates wrong capture, missing chip-enable independence and latency errors. Bursts are started from each of the four counter seeds in both read and write form, which exposes wrong wrap order or disturbed upper bits. Directed cases cover the following:
- both strobes at once with a write request;
- a gated processor strobe;
- a read right after a write to the same word;
- toggling output enable;
- a sleep span followed by the wake cycle.

Each of these is told apart by comparing the read-back words against values computed arithmetically from the address.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  // Kind of access accepted at a clock edge
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_PROC = 2'd1,
    ACC_CTRL = 2'd2,
    ACC_ADV  = 2'd3
  } acc_kind_t;

  localparam int unsigned BURST_W = 2;
endpackage

// File: rtl/sfe_strobe_arb.sv
module sfe_strobe_arb
  import sfe_pkg::*;
(
  input  logic      proc_stb_n,
  input  logic      ctrl_stb_n,
  input  logic      ce1_n,
  input  logic      adv_n,
  input  logic      active,
  output acc_kind_t kind
);
  always_comb begin
    kind = ACC_NONE;
    if (active) begin
      if (!proc_stb_n && !ce1_n)
        kind = ACC_PROC;
      else if (!ctrl_stb_n)
        kind = ACC_CTRL;
      else if (!adv_n)
        kind = ACC_ADV;
    end
  end
endmodule

// File: rtl/sfe_burst_addr.sv
module sfe_burst_addr
  import sfe_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_kind_t         kind,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int unsigned UP_W = ADDR_W - BURST_W;

  logic [UP_W-1:0]    up_q;
  logic [BURST_W-1:0] cnt_q;
  logic [UP_W-1:0]    up_d;
  logic [BURST_W-1:0] cnt_d;

  always_comb begin
    up_d  = up_q;
    cnt_d = cnt_q;
    case (kind)
      ACC_PROC, ACC_CTRL: begin
        up_d  = addr_in[ADDR_W-1:BURST_W];
        cnt_d = addr_in[BURST_W-1:0];
      end
      ACC_ADV: cnt_d = cnt_q + 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q  <= '0;
      cnt_q <= '0;
    end else begin
      up_q  <= up_d;
      cnt_q <= cnt_d;
    end
  end

  assign nxt_addr = {up_d, cnt_d};
  assign cur_addr = {up_q, cnt_q};
endmodule

// File: rtl/sfe_mem_array.sv
module sfe_mem_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_data_q;
  logic [DATA_W-1:0] rd_q;

  // Registered write request (address and bus data)
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else begin
      pend_q      <= req_wr;
      pend_addr_q <= req_addr;
      pend_data_q <= req_data;
    end
  end

  // Array write port, no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (pend_q)
      mem[pend_addr_q] <= pend_data_q;
  end

  // Registered read with bypass of the write being committed
  always_ff @(posedge clk) begin
    if (rst)
      rd_q <= '0;
    else if (rd_en) begin
      if (pend_q && (pend_addr_q == rd_addr))
        rd_q <= pend_data_q;
      else
        rd_q <= mem[rd_addr];
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/burst_sram_frontend.sv
module burst_sram_frontend
  import sfe_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              proc_stb_n,
  input  logic              ctrl_stb_n,
  input  logic              ce1_n,
  input  logic              adv_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              sleep,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  acc_kind_t         kind;
  logic              sleep_q;
  logic              active;
  logic              oe_q;
  logic              wr_req;
  logic [ADDR_W-1:0] nxt_addr;
  logic [ADDR_W-1:0] cur_addr;

  // Sleep history: the edge after sleep falls is still idle
  always_ff @(posedge clk) begin
    if (rst) begin
      sleep_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      sleep_q <= sleep;
      oe_q    <= !oe_n && !sleep;
    end
  end

  assign active = !sleep && !sleep_q;

  sfe_strobe_arb u_arb (
    .proc_stb_n (proc_stb_n),
    .ctrl_stb_n (ctrl_stb_n),
    .ce1_n      (ce1_n),
    .adv_n      (adv_n),
    .active     (active),
    .kind       (kind)
  );

  sfe_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .kind     (kind),
    .addr_in  (addr),
    .nxt_addr (nxt_addr),
    .cur_addr (cur_addr)
  );

  assign wr_req = ((kind == ACC_CTRL) || (kind == ACC_ADV)) && !we_n;

  sfe_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk      (clk),
    .rst      (rst),
    .req_wr   (wr_req),
    .req_addr (nxt_addr),
    .req_data (dq_in),
    .rd_en    (!sleep),
    .rd_addr  (cur_addr),
    .rd_data  (dq_out)
  );

  assign dq_oe = oe_q;
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              proc_stb_n,
  input logic              ctrl_stb_n,
  input logic              ce1_n,
  input logic              adv_n,
  input logic              oe_n,
  input logic              sleep,
  input logic              sleep_q,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe
);
  // R1: controller strobe while active captures the address
  p_capture_r1: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_stb_n && !sleep && !sleep_q) |=> (cur_addr == $past(addr)));

  // R3: gated processor strobe with nothing else leaves the address alone
  p_ce_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (ce1_n && ctrl_stb_n && adv_n) |=> $stable(cur_addr));

  // R5: advance increments the low bits and keeps the upper bits
  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !sleep_q && proc_stb_n && ctrl_stb_n && !adv_n) |=>
      ((cur_addr[1:0] == 2'($past(cur_addr[1:0]) + 2'd1)) &&
       (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]))));

  // R8: output enable high tri-states the bus after the edge
  p_oe_off_r8: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> !dq_oe);

  // R9: sleep blocks the bus and freezes read data
  p_sleep_r9: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (!dq_oe && $stable(dq_out)));

  // R10: the wake cycle accepts nothing
  p_wake_r10: assert property (@(posedge clk) disable iff (rst)
    (sleep_q && !sleep) |=> $stable(cur_addr));

  // R11: reset leaves the bus tri-stated and read data cleared
  p_reset_r11: assert property (@(posedge clk)
    rst |=> (!dq_oe && (dq_out == '0) && (cur_addr == '0)));
endmodule

bind burst_sram_frontend sfe_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .proc_stb_n (proc_stb_n),
  .ctrl_stb_n (ctrl_stb_n),
  .ce1_n      (ce1_n),
  .adv_n      (adv_n),
  .oe_n       (oe_n),
  .sleep      (sleep),
  .sleep_q    (sleep_q),
  .addr       (addr),
  .cur_addr   (cur_addr),
  .dq_out     (dq_out),
  .dq_oe      (dq_oe)
);

// File: tb/sim_burst_sram_frontend.sv
`timescale 1ns/1ps
module sim_burst_sram_frontend;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          proc_stb_n = 1'b1, ctrl_stb_n = 1'b1, ce1_n = 1'b1, adv_n = 1'b1;
  logic          we_n = 1'b1, oe_n = 1'b1, sleep = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  always #2 clk = ~clk;

  burst_sram_frontend #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
    .ce1_n(ce1_n), .adv_n(adv_n), .we_n(we_n), .oe_n(oe_n), .sleep(sleep),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Reference state, derived from the requirements
  logic [DW-1:0] m_mem [DEPTH];
  bit            m_known [DEPTH];
  logic [AW-1:0] m_cur = '0;
  logic [DW-1:0] m_dout = '0;
  bit            m_dk = 1;
  bit            m_oe = 0;
  bit            m_slp = 0;

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'((a * 37 + salt * 11 + 5) & 8'hff);
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: drive, predict, wait past the edge, compare
  task automatic cyc(input bit p, input bit c, input bit ce, input bit adv, input bit we,
                     input bit oe, input bit slp, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input string req);
    bit act, pa, ca, aa;
    logic [AW-1:0] nx;
    proc_stb_n = p; ctrl_stb_n = c; ce1_n = ce; adv_n = adv; we_n = we;
    oe_n = oe; sleep = slp; addr = a; dq_in = d;
    act = !slp && !m_slp;
    pa  = act && !p && !ce;
    ca  = act && !c && !pa;
    aa  = act && !pa && !ca && !adv;
    if (!slp) begin
      m_dk   = m_known[m_cur];
      m_dout = m_mem[m_cur];
    end
    nx = m_cur;
    if (pa || ca) nx = a;
    else if (aa) nx = {m_cur[AW-1:2], 2'(m_cur[1:0] + 2'd1)};
    if ((ca || aa) && !we) begin
      m_mem[nx] = d;
      m_known[nx] = 1;
    end
    m_cur = nx;
    m_oe  = !oe && !slp;
    m_slp = slp;
    @(posedge clk); #1;
    check(dq_oe === m_oe, req, DW'(dq_oe), DW'(m_oe));
    if (m_dk) check(dq_out === m_dout, req, dq_out, m_dout);
  endtask

  task automatic idle(input bit oe, input string req);
    cyc(1, 1, 1, 1, 1, oe, 0, '0, '0, req);
  endtask

  task automatic do_reset(input string req);
    proc_stb_n = 1; ctrl_stb_n = 1; adv_n = 1; we_n = 1; oe_n = 0; sleep = 0;
    rst = 1;
    @(posedge clk); #1;
    rst = 0;
    m_cur = '0; m_dout = '0; m_dk = 1; m_oe = 0; m_slp = 0;
    check(dq_oe === 1'b0, req, DW'(dq_oe), '0);
    check(dq_out === '0, req, dq_out, '0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_known[i] = 0;
    repeat (2) @(posedge clk);
    #1;
    // R11: state after the initial reset
    rst = 0;
    check(dq_oe === 1'b0, "R11", DW'(dq_oe), '0);
    check(dq_out === '0, "R11", dq_out, '0);

    // R4: fill the array with controller strobes while ce1_n is high
    for (int a = 0; a < DEPTH; a++) cyc(1, 0, 1, 1, 0, 1, 0, AW'(a), pat(a, 0), "R4");
    idle(0, "R4");

    // R1: processor strobe read of every word, idle between reads
    for (int a = DEPTH - 1; a >= 0; a--) begin
      cyc(0, 1, 0, 1, 1, 0, 0, AW'(a), '0, "R1");
      idle(0, "R1");
    end

    // R7: back-to-back reads at consecutive edges
    for (int a = 0; a < DEPTH; a += 3) cyc(0, 1, 0, 1, 1, 0, 0, AW'(a), '0, "R7");
    idle(0, "R7");

    // R5: read bursts from each counter seed, wrapping 3 -> 0
    for (int s = 0; s < 4; s++) begin
      cyc(0, 1, 0, 1, 1, 0, 0, AW'(8'h14 + s), '0, "R5");
      for (int k = 0; k < 4; k++) cyc(1, 1, 1, 0, 1, 0, 0, '0, '0, "R5");
      idle(0, "R5");
    end

    // R6: write burst by controller strobe and advances, then read back
    for (int s = 0; s < 4; s++) begin
      cyc(1, 0, 1, 1, 0, 0, 0, AW'(8'h20 + 4 * s + s), pat(s, 1), "R6");
      for (int k = 0; k < 3; k++) cyc(1, 1, 1, 0, 0, 0, 0, '0, pat(s * 4 + k, 2), "R6");
      idle(0, "R6");
      cyc(0, 1, 0, 1, 1, 0, 0, AW'(8'h20 + 4 * s), '0, "R6");
      for (int k = 0; k < 4; k++) cyc(1, 1, 1, 0, 1, 0, 0, '0, '0, "R6");
    end
    // R6: processor strobe with we_n low does not write
    cyc(0, 1, 0, 1, 0, 0, 0, AW'(8'h30), 8'hee, "R6");
    idle(0, "R6");
    cyc(0, 1, 0, 1, 1, 0, 0, AW'(8'h30), '0, "R6");
    idle(0, "R6");

    // R2: both strobes with a write request: processor wins, no write
    cyc(0, 0, 0, 1, 0, 0, 0, AW'(8'h31), 8'h5a, "R2");
    idle(0, "R2");
    cyc(0, 1, 0, 1, 1, 0, 0, AW'(8'h31), '0, "R2");
    idle(0, "R2");

    // R3: gated processor strobe keeps the previous burst address
    cyc(0, 1, 0, 1, 1, 0, 0, AW'(8'h05), '0, "R3");
    cyc(0, 1, 1, 1, 1, 0, 0, AW'(8'h3a), '0, "R3");
    idle(0, "R3");
    idle(0, "R3");

    // R12: read right after a write to the same word
    for (int a = 8; a < 16; a++) begin
      cyc(1, 0, 0, 1, 0, 0, 0, AW'(a), pat(a, 3), "R12");
      cyc(0, 1, 0, 1, 1, 0, 0, AW'(a), '0, "R12");
      idle(0, "R12");
    end

    // R8: output enable toggling
    for (int k = 0; k < 8; k++) idle(k[0] ^ k[2], "R8");

    // R9: accesses and writes during sleep are ignored, bus off
    cyc(0, 1, 0, 1, 1, 0, 0, AW'(8'h09), '0, "R9");
    for (int k = 0; k < 4; k++) cyc(1, 0, 0, 0, 0, 0, 1, AW'(8'h09), 8'h77, "R9");
    // R10: wake cycle ignores a controller write
    cyc(1, 0, 1, 1, 0, 0, 0, AW'(8'h0a), 8'h66, "R10");
    idle(0, "R10");
    cyc(0, 1, 0, 1, 1, 0, 0, AW'(8'h0a), '0, "R10");
    idle(0, "R10");
    cyc(0, 1, 0, 1, 1, 0, 0, AW'(8'h09), '0, "R9");
    idle(0, "R9");

    // R11: mid-run reset, then contents still readable
    do_reset("R11");
    cyc(0, 1, 0, 1, 1, 0, 0, AW'(8'h21), '0, "R11");
    idle(0, "R11");

    summary();
  end
endmodule